// File: doc/BRIEF.md
# Wrap-Loopback Serializer

This block is the transmit half of a 10-bit serial link. It runs on one clock at the serial bit rate. A word strobe, high for one cycle in every ten, marks where each word-clock edge falls. On a strobe cycle the block takes the pre-encoded parallel word into a holding register. A fixed number of cycles later it moves the word into a shift register. From there the word leaves one bit per cycle, starting with bit 0, so each word takes ten cycles.

A wrap control selects where the serial stream goes. In normal mode the stream drives the differential-style line output pair, and the loopback output rests high. In wrap mode the stream goes to the loopback output, which feeds the local receive path. The line pair is then parked at a static logic one: true output high, complement output low. The mode is sampled only when a word enters the shift register, so each word goes out whole on one path. When no new word arrives in time, both outputs go back to the idle-high level.

Top module: `wrap_serializer`

## Requirements
- R1: While `rst_ni` is low and after reset is released, `line_p_o`=1, `line_n_o`=0 and `loop_o`=1 until the first word starts.
- R2: `word_i` is sampled only in a cycle where `word_stb_i` is high. Changes to `word_i` in other cycles do not alter the serial bits sent.
- R3: Let E be the clock edge that samples a strobe. Bit k of the captured word (k=0 first, LSB first) is presented on the active output in the cycle after edge E+4+k, which is a latency of four bit times.
- R4: When strobes are exactly ten cycles apart, the words follow each other on the output with no idle bit between them.
- R5: With `wrap_en_i`=1 the serial bits appear on `loop_o`, and `line_p_o`=1 with `line_n_o`=0 for the whole word.
- R6: With `wrap_en_i`=0 the serial bits appear on `line_p_o`, and `loop_o` stays 1.
- R7: `wrap_en_i` is sampled once per word, three cycles after its strobe edge. A change in the middle of a word takes effect from bit 0 of the next word.
- R8: After bit 9 of a word, if no further word has loaded, `line_p_o` and `loop_o` return to 1.
- R9: `line_n_o` is always the complement of `line_p_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Serial bit-rate clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| word_stb_i | input | 1 | One-cycle word strobe, one cycle in every WORD_W |
| word_i | input | WORD_W | Pre-encoded parallel word |
| wrap_en_i | input | 1 | Route the stream to loopback and park the line high |
| line_p_o | output | 1 | Line output, true side |
| line_n_o | output | 1 | Line output, complement side |
| loop_o | output | 1 | Serial stream toward the local receiver |

## Verification
The bench builds the block with WORD_W=10 and LOAD_DLY=3. At these values one word fills exactly ten cycles, and the four-bit-time latency can be checked at a fixed cycle offset after each strobe. The bench keeps a per-cycle table of expected line and loopback levels. It therefore covers back-to-back words, gaps that fall back to idle, and a wrap toggle in the middle of a word. The words used include all ones, all zeros and alternating patterns, which expose shift-direction and word-seam errors.

// File: rtl/wrap_ser_pkg.sv
package wrap_ser_pkg;
  typedef enum logic {
    PATH_LINE = 1'b0,
    PATH_LOOP = 1'b1
  } path_e;
endpackage

// File: rtl/ws_capture.sv
module ws_capture #(
  parameter int WORD_W   = 10,
  parameter int LOAD_DLY = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stb_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] hold_o,
  output logic              load_o
);
  logic [WORD_W-1:0]   hold_q;
  logic [LOAD_DLY-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    hold_q <= '0;
    else if (stb_i) hold_q <= word_i;
  end

  generate
    if (LOAD_DLY == 1) begin : g_dly1
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q <= '0;
        else         pipe_q <= stb_i;
      end
    end else begin : g_dlyn
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q <= '0;
        else         pipe_q <= {pipe_q[LOAD_DLY-2:0], stb_i};
      end
    end
  endgenerate

  assign hold_o = hold_q;
  assign load_o = pipe_q[LOAD_DLY-1];

  // R2: the holding register takes the word only on a strobe
  a_r2_capture_on_stb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_i |=> hold_o == $past(word_i));
  a_r2_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stb_i |=> $stable(hold_o));
endmodule

// File: rtl/ws_shifter.sv
module ws_shifter
  import wrap_ser_pkg::*;
#(
  parameter int WORD_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] hold_i,
  input  logic              wrap_i,
  output logic              bit_o,
  output logic              vld_o,
  output path_e             path_o
);
  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] CNT_IDLE = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WORD_W - 1);

  logic [WORD_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;
  path_e             path_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '1;
      cnt_q  <= CNT_IDLE;
      path_q <= PATH_LINE;
    end else if (load_i) begin
      sh_q   <= hold_i;
      cnt_q  <= '0;
      path_q <= wrap_i ? PATH_LOOP : PATH_LINE;
    end else begin
      sh_q <= {1'b1, sh_q[WORD_W-1:1]};
      if (cnt_q != CNT_IDLE) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign bit_o  = sh_q[0];
  assign vld_o  = (cnt_q != CNT_IDLE);
  assign path_o = path_q;

  // R4: a new word loads only at a word seam or from idle
  a_r4_load_at_seam: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> (cnt_q == CNT_LAST || cnt_q == CNT_IDLE));
  // R3: first bit presented after a load is bit 0 of the held word
  a_r3_lsb_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> bit_o == $past(hold_i[0]));
  // R7: path is frozen inside a word
  a_r7_path_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(path_o));
endmodule

// File: rtl/ws_outstage.sv
module ws_outstage
  import wrap_ser_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  bit_i,
  input  logic  vld_i,
  input  path_e path_i,
  output logic  line_p_o,
  output logic  line_n_o,
  output logic  loop_o
);
  logic line_p_q, line_n_q, loop_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_p_q <= 1'b1;
      line_n_q <= 1'b0;
      loop_q   <= 1'b1;
    end else if (!vld_i) begin
      line_p_q <= 1'b1;
      line_n_q <= 1'b0;
      loop_q   <= 1'b1;
    end else begin
      case (path_i)
        PATH_LOOP: begin
          line_p_q <= 1'b1;
          line_n_q <= 1'b0;
          loop_q   <= bit_i;
        end
        default: begin
          line_p_q <= bit_i;
          line_n_q <= ~bit_i;
          loop_q   <= 1'b1;
        end
      endcase
    end
  end

  assign line_p_o = line_p_q;
  assign line_n_o = line_n_q;
  assign loop_o   = loop_q;

  // R5: wrap parks the line pair high
  a_r5_line_parked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && path_i == PATH_LOOP) |=> (line_p_o && !line_n_o));
  // R6: normal mode leaves loopback idle
  a_r6_loop_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (path_i == PATH_LINE) |=> loop_o);
  // R8: no active bit means idle high on both paths
  a_r8_idle_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i |=> (line_p_o && loop_o));
endmodule

// File: rtl/wrap_serializer.sv
module wrap_serializer
  import wrap_ser_pkg::*;
#(
  parameter int WORD_W   = 10,
  parameter int LOAD_DLY = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              word_stb_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              wrap_en_i,
  output logic              line_p_o,
  output logic              line_n_o,
  output logic              loop_o
);
  logic [WORD_W-1:0] hold;
  logic              load;
  logic              sbit;
  logic              svld;
  path_e             spath;

  ws_capture #(.WORD_W(WORD_W), .LOAD_DLY(LOAD_DLY)) i_capture (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .stb_i  (word_stb_i),
    .word_i (word_i),
    .hold_o (hold),
    .load_o (load)
  );

  ws_shifter #(.WORD_W(WORD_W)) i_shifter (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .hold_i (hold),
    .wrap_i (wrap_en_i),
    .bit_o  (sbit),
    .vld_o  (svld),
    .path_o (spath)
  );

  ws_outstage i_outstage (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bit_i    (sbit),
    .vld_i    (svld),
    .path_i   (spath),
    .line_p_o (line_p_o),
    .line_n_o (line_n_o),
    .loop_o   (loop_o)
  );

  // R9: line pair always complementary
  a_r9_complement: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_p_o != line_n_o);
endmodule

// File: tb/test_wrap_serializer.sv
module test_wrap_serializer;
  localparam int W     = 10;
  localparam int DLY   = 3;
  localparam int DEPTH = 4096;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         word_stb_i = 1'b0;
  logic [W-1:0] word_i = '0;
  logic         wrap_en_i = 1'b0;
  logic         line_p_o, line_n_o, loop_o;

  int    checks = 0;
  int    errors = 0;
  int    cyc = 0;
  bit    done = 0;
  string tag = "R1";
  bit    exp_line [DEPTH];
  bit    exp_loop [DEPTH];

  always #10 clk = ~clk;

  wrap_serializer #(.WORD_W(W), .LOAD_DLY(DLY)) i_wrap_serializer (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .word_stb_i (word_stb_i),
    .word_i     (word_i),
    .wrap_en_i  (wrap_en_i),
    .line_p_o   (line_p_o),
    .line_n_o   (line_n_o),
    .loop_o     (loop_o)
  );

  task automatic tick();
    @(negedge clk);
    cyc++;
    checks++;
    if (line_p_o !== exp_line[cyc]) begin
      errors++;
      $display("FAIL %s line_p_o cyc %0d actual %b expected %b", tag, cyc, line_p_o, exp_line[cyc]);
    end
    checks++;
    if (loop_o !== exp_loop[cyc]) begin
      errors++;
      $display("FAIL %s loop_o cyc %0d actual %b expected %b", tag, cyc, loop_o, exp_loop[cyc]);
    end
    checks++;
    if (line_n_o !== ~line_p_o) begin // R9
      errors++;
      $display("FAIL R9 line_n_o cyc %0d actual %b expected %b", cyc, line_n_o, ~line_p_o);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  // strobe a word; bit k expected at tick c0+5+k on the path chosen by wr
  task automatic send(input logic [W-1:0] w, input logic wr, input bit flip_wrap);
    int c0 = cyc;
    word_i     = w;
    word_stb_i = 1'b1;
    wrap_en_i  = wr;
    for (int k = 0; k < W; k++) begin
      if (wr) begin
        exp_loop[c0+5+k] = w[k];
        exp_line[c0+5+k] = 1'b1;
      end else begin
        exp_line[c0+5+k] = w[k];
        exp_loop[c0+5+k] = 1'b1;
      end
    end
    tick();
    word_stb_i = 1'b0;
    word_i     = ~w; // R2: off-strobe changes must not leak
    for (int i = 1; i < W; i++) begin
      tick();
      if (flip_wrap && i == 6) wrap_en_i = ~wr; // R7: mid-word toggle
      word_i = word_i ^ 10'h0F3;
    end
  endtask

  task automatic t_reset();
    tag = "R1";
    idle(3);
    rst_ni = 1'b1;
    idle(4);
  endtask

  task automatic t_single();
    tag = "R3";
    send(10'h2B5, 1'b0, 1'b0);
    tag = "R8";
    idle(10);
  endtask

  task automatic t_capture();
    tag = "R2";
    send(10'h0C7, 1'b0, 1'b0);
    idle(8);
  endtask

  task automatic t_stream();
    tag = "R4";
    send(10'h3FF, 1'b0, 1'b0);
    send(10'h000, 1'b0, 1'b0);
    send(10'h155, 1'b0, 1'b0);
    send(10'h2AA, 1'b0, 1'b0);
    idle(8);
  endtask

  task automatic t_normal();
    tag = "R6";
    send(10'h3E0, 1'b0, 1'b0);
    send(10'h01F, 1'b0, 1'b0);
    idle(8);
  endtask

  task automatic t_wrap();
    tag = "R5";
    send(10'h19A, 1'b1, 1'b0);
    send(10'h265, 1'b1, 1'b0);
    idle(8);
    wrap_en_i = 1'b0;
  endtask

  task automatic t_wrap_switch();
    tag = "R7";
    send(10'h11D, 1'b0, 1'b1);
    send(10'h2E2, 1'b1, 1'b1);
    send(10'h0F0, 1'b0, 1'b0);
    idle(8);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      exp_line[i] = 1'b1;
      exp_loop[i] = 1'b1;
    end
    t_reset();
    t_single();
    t_capture();
    t_stream();
    t_normal();
    t_wrap();
    t_wrap_switch();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog expired at cyc %0d actual running expected finished", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule